// File: doc/BRIEF.md
# Dual-Channel Programmable Timer

This peripheral holds two independent 32-bit counting channels behind one small register window. Each channel has a control word, a reload value and a live count. The count can step up or down by one per clock. It can be forced to the reload value. When it reaches its terminal value it can restart from the reload value and keep running, which gives a periodic tick. Otherwise it stops at the terminal value, which gives a single timeout.

Software reaches the registers over a word-addressed bus with separate read and write strobes. Read data appears one clock after the read strobe. Each channel keeps a sticky event flag, and the flag is cleared by writing a 1 to it. The block drives one interrupt line for both channels. A typical setup runs one channel as a periodic or one-shot event source and the other as a free-running up counter used as a time base.

Word addresses use bit 2 to select the channel and bits 1:0 to select the register: 0 is control, 1 is reload and 2 is count. Control-word bits are mode (0), down (1), generate-out enable (2), capture enable (3), auto-reload (4), force-load (5), interrupt enable (6), run (7), event flag (8), PWM enable (9) and run-both (10).

Top module: `dual_ch_timer`

## Requirements
- R1: After reset, every control, reload and count register of both channels reads 0, and `irq` is low.
- R2: Writing 0 to a reload register stores 1. Any other value is stored unchanged.
- R3: While the force-load bit (bit 5) is set, the count register takes the reload value on every clock, whether or not the run bit is set.
- R4: With run (bit 7), down (bit 1) and auto-reload (bit 4) set, and the count just forced to reload value L, the first event occurs L+1 clocks after the control write.
- R5: In that down, auto-reload setup, events repeat every L+1 clocks. The count goes L, L-1, …, 0 and then reloads to L on the clock that raises the event flag.
- R6: `irq` is high while either channel has its event flag (bit 8) and its interrupt-enable bit (bit 6) both set.
- R7: Writing 1 to bit 8 clears the event flag, and writing 0 leaves it unchanged. Writing back the value just read therefore acknowledges a pending event. If an event and a clearing write fall on the same clock, the event wins.
- R8: With bit 6 clear, an event still sets bit 8, but `irq` stays low.
- R9: With bit 1 clear the count increments. The terminal value is 0xFFFFFFFF, and with auto-reload the count restarts from the reload value, so a reload of 0xFFFFFFFF-k gives events every k+1 clocks. With the reload value left at 0, the channel runs as a free-running up counter.
- R10: Without auto-reload, the count stops at the terminal value after the event and raises no further events until it is loaded again or the run bit is cleared.
- R11: Clearing the run bit freezes the count at its current value, and the count stays readable.
- R12: A control write with bit 10 set sets the run bit of both channels on the same clock.
- R13: Bits 0, 2, 3, 9 and 10 are stored and read back as written, and they do not change counting or event timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Word address: bit 2 selects the channel, bits 1:0 select the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after `bus_rd` |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest states to reach are the terminal-count edge cases: the up-counting wrap at 0xFFFFFFFF and a periodic channel whose period is a single clock. A free-running count would take billions of clocks to get to either one. The stimulus reaches them by loading reload values just below the wrap point and by sweeping small reload values, including the zero that becomes one. It then times the rise of `irq` after each start and after each acknowledge, and compares the measured latency with the period worked out from the reload value.

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int unsigned CTL_BITS  = 11;
    localparam int unsigned BIT_RUN   = 7;
    localparam int unsigned BIT_FLAG  = 8;
    localparam int unsigned BIT_BOTH  = 10;

    // Field order follows the control-word bit positions (MSB first).
    typedef struct packed {
        logic both;     // 10: run both channels
        logic pwm;      // 9 : stored only
        logic flag;     // 8 : event flag, write 1 to clear
        logic run;      // 7 : counting enabled
        logic ie;       // 6 : interrupt enable
        logic ld;       // 5 : force count to reload value
        logic arl;      // 4 : auto-reload
        logic capt;     // 3 : stored only
        logic gout;     // 2 : stored only
        logic down;     // 1 : count direction
        logic mode;     // 0 : stored only
    } ctl_t;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_LOAD = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/dct_channel.sv
module dct_channel
    import dct_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             load_we,
    input  logic             run_force,
    input  logic [CNT_W-1:0] wdata,
    output ctl_t             ctl_o,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LOAD_MIN = CNT_W'(1);

    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cnt;
        logic             spent;   // one-shot already fired at terminal
    } chan_st_t;

    chan_st_t         st_d, st_q;
    logic [CNT_W-1:0] term_val;
    logic             at_term;
    logic             fire;

    always_comb begin
        st_d     = st_q;
        term_val = st_q.ctl.down ? '0 : '1;
        at_term  = (st_q.cnt == term_val);
        fire     = 1'b0;

        // register writes
        if (ctl_we) begin
            st_d.ctl      = ctl_t'(wdata[CTL_BITS-1:0]);
            st_d.ctl.flag = st_q.ctl.flag & ~wdata[BIT_FLAG];
            st_d.ctl.run  = wdata[BIT_RUN] | wdata[BIT_BOTH];
        end
        if (run_force) begin
            st_d.ctl.run = 1'b1;
        end
        if (load_we) begin
            st_d.load = (wdata == '0) ? LOAD_MIN : wdata;
        end

        // counting, driven by the currently held control word
        if (st_q.ctl.ld) begin
            st_d.cnt   = st_q.load;
            st_d.spent = 1'b0;
        end else if (!st_q.ctl.run) begin
            st_d.spent = 1'b0;
        end else if (at_term) begin
            if (!st_q.spent) begin
                fire       = 1'b1;
                st_d.cnt   = st_q.ctl.arl ? st_q.load : st_q.cnt;
                st_d.spent = ~st_q.ctl.arl;
            end
        end else if (st_q.ctl.down) begin
            st_d.cnt = st_q.cnt - LOAD_MIN;
        end else begin
            st_d.cnt = st_q.cnt + LOAD_MIN;
        end

        // an event outranks a clearing write on the same clock
        if (fire) begin
            st_d.ctl.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o  = st_q.ctl;
    assign load_o = st_q.load;
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/dct_regif.sv
module dct_regif
    import dct_pkg::*;
#(
    parameter  int unsigned NCH    = 2,
    parameter  int unsigned DATA_W = 32,
    localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int unsigned AW     = CH_W + 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [AW-1:0]                 bus_addr,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [DATA_W-1:0]             bus_wdata,
    input  ctl_t [NCH-1:0]                ctl_i,
    input  logic [NCH-1:0][DATA_W-1:0]    load_i,
    input  logic [NCH-1:0][DATA_W-1:0]    cnt_i,
    output logic [NCH-1:0]                ctl_we,
    output logic [NCH-1:0]                load_we,
    output logic [NCH-1:0]                run_force,
    output logic [DATA_W-1:0]             bus_rdata
);

    logic [CH_W-1:0]   ch_idx;
    reg_sel_e          sel;
    logic              ch_ok;
    logic              both_wr;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    assign ch_idx  = bus_addr[AW-1:2];
    assign sel     = reg_sel_e'(bus_addr[1:0]);
    assign ch_ok   = (32'(ch_idx) < NCH);
    assign both_wr = bus_wr && ch_ok && (sel == SEL_CTL) && bus_wdata[BIT_BOTH];

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign ctl_we[i]    = bus_wr && (sel == SEL_CTL)  && (ch_idx == CH_W'(i));
        assign load_we[i]   = bus_wr && (sel == SEL_LOAD) && (ch_idx == CH_W'(i));
        assign run_force[i] = both_wr;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd) begin
            rdata_d = '0;
            if (ch_ok) begin
                case (sel)
                    SEL_CTL:  rdata_d = DATA_W'(ctl_i[ch_idx]);
                    SEL_LOAD: rdata_d = load_i[ch_idx];
                    SEL_CNT:  rdata_d = cnt_i[ch_idx];
                    default:  rdata_d = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/dual_ch_timer.sv
module dual_ch_timer
    import dct_pkg::*;
#(
    parameter  int unsigned NCH    = 2,
    parameter  int unsigned CNT_W  = 32,
    localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int unsigned ADDR_W = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    ctl_t [NCH-1:0]             ctl_arr;
    logic [NCH-1:0][CNT_W-1:0]  load_arr;
    logic [NCH-1:0][CNT_W-1:0]  cnt_arr;
    logic [NCH-1:0]             ctl_we, load_we, run_force;
    logic [NCH-1:0]             flag_vec, ie_vec, run_vec, ld_vec;

    dct_regif #(
        .NCH    (NCH),
        .DATA_W (CNT_W)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .ctl_i     (ctl_arr),
        .load_i    (load_arr),
        .cnt_i     (cnt_arr),
        .ctl_we    (ctl_we),
        .load_we   (load_we),
        .run_force (run_force),
        .bus_rdata (bus_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dct_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_we    (ctl_we[i]),
            .load_we   (load_we[i]),
            .run_force (run_force[i]),
            .wdata     (bus_wdata),
            .ctl_o     (ctl_arr[i]),
            .load_o    (load_arr[i]),
            .cnt_o     (cnt_arr[i])
        );
        assign flag_vec[i] = ctl_arr[i].flag;
        assign ie_vec[i]   = ctl_arr[i].ie;
        assign run_vec[i]  = ctl_arr[i].run;
        assign ld_vec[i]   = ctl_arr[i].ld;
    end

    assign irq = |(flag_vec & ie_vec);

endmodule

// File: rtl/dct_chk.sv
module dct_chk #(
    parameter int unsigned NCH   = 2,
    parameter int unsigned CNT_W = 32,
    parameter int unsigned AW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_wr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             irq,
    input logic [NCH-1:0]   flag_vec,
    input logic [NCH-1:0]   run_vec,
    input logic [NCH-1:0]   ld_vec,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] load0
);

    // R3
    load_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vec[0] |=> (cnt0 == $past(load0)));

    // R11
    frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_vec[0] && !ld_vec[0]) |=> $stable(cnt0));

    // R2
    nonzero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(1)) |=> (load0 != '0));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_vec[0]) |-> $past(bus_wr && bus_addr == AW'(0) && bus_wdata[8]));

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|flag_vec));

    // R12
    run_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1:0] == 2'd0 && bus_wdata[10]) |=> (&run_vec));

endmodule

bind dual_ch_timer dct_chk #(
    .NCH   (NCH),
    .CNT_W (CNT_W),
    .AW    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .flag_vec  (flag_vec),
    .run_vec   (run_vec),
    .ld_vec    (ld_vec),
    .cnt0      (cnt_arr[0]),
    .load0     (load_arr[0])
);

// File: tb/sim_dual_ch_timer.sv
`timescale 1ns/1ps
module sim_dual_ch_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dual_ch_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!irq && n < 2000);
    endtask

    task automatic quiesce();
        for (int k = 0; k < 2; k++) begin
            wr(3'd0, 32'h100);
            wr(3'd4, 32'h100);
        end
    endtask

    task automatic start(input logic [2:0] ch, input logic [31:0] ld, input logic [31:0] ctl);
        wr(ch | 3'd1, ld);
        wr(ch, 32'h20);
        wr(ch, ctl);
    endtask

    initial begin
        logic [31:0] v, a, b;
        int n;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        foreach (v[i]) if (i < 7 && i != 3) begin
            rd(3'(i), v); chk("R1 reg", v, 32'h0);
        end

        // R12 run-both from channel 0
        wr(3'd0, 32'h400);
        rd(3'd4, v); chk("R12 ch1 run", v, 32'h80);
        rd(3'd0, v); chk("R12 ch0 run", v, 32'h480);
        quiesce();

        // R2 zero reload becomes one
        wr(3'd1, 32'h0); rd(3'd1, v); chk("R2 ch0", v, 32'h1);
        wr(3'd5, 32'h0); rd(3'd5, v); chk("R2 ch1", v, 32'h1);
        wr(3'd5, 32'h7); rd(3'd5, v); chk("R2 plain", v, 32'h7);

        // R3 force-load holds count at reload value
        wr(3'd1, 32'h1234); wr(3'd0, 32'h20); idle(1);
        rd(3'd2, v); chk("R3 forced", v, 32'h1234);
        wr(3'd1, 32'h55); idle(1);
        rd(3'd2, v); chk("R3 follow", v, 32'h55);
        wr(3'd0, 32'hA2); idle(3);
        rd(3'd2, v); chk("R3 run+load", v, 32'h55);
        quiesce();

        // R4 R5 down periodic sweep, including zero reload
        for (int L = 0; L <= 6; L++) begin
            int eff;
            eff = (L == 0) ? 1 : L;
            quiesce();
            start(3'd0, 32'(L), 32'h1D2);
            wait_irq(n); chk("R4 first event", 32'(n), 32'(eff + 1));
            for (int k = 0; k < 2; k++) begin
                wr(3'd0, 32'h1D2);
                wait_irq(n); chk("R5 period after ack", 32'(n), 32'(eff));
            end
        end

        // R7 write-one-to-clear
        quiesce();
        start(3'd0, 32'd20, 32'h1D2);
        wait_irq(n); chk("R4 L=20", 32'(n), 32'd21);
        rd(3'd0, v); chk("R7 flag set", v, 32'h1D2);
        wr(3'd0, 32'hD2);
        rd(3'd0, v); chk("R7 zero keeps", v, 32'h1D2);
        chk("R7 irq held", {31'b0, irq}, 32'h1);
        wr(3'd0, v);
        chk("R7 writeback clears irq", {31'b0, irq}, 32'h0);
        rd(3'd0, v); chk("R7 flag cleared", v, 32'hD2);

        // R6 channel 1 drives the shared line
        quiesce();
        start(3'd4, 32'd2, 32'h1D2);
        wait_irq(n); chk("R6 ch1 irq", 32'(n), 32'd3);
        rd(3'd0, v); chk("R6 ch0 idle", v, 32'h0);

        // R8 event without interrupt enable
        quiesce();
        start(3'd0, 32'd2, 32'h92);
        seen = 0;
        for (int k = 0; k < 10; k++) begin idle(1); if (irq) seen = 1; end
        chk("R8 irq masked", {31'b0, seen}, 32'h0);
        rd(3'd0, v); chk("R8 flag set", v, 32'h192);

        // R9 up wrap with small periods
        for (int k = 0; k <= 3; k++) begin
            quiesce();
            start(3'd0, 32'hFFFF_FFFF - 32'(k), 32'h1D0);
            wait_irq(n); chk("R9 first wrap", 32'(n), 32'(k + 1));
            if (k > 0) begin
                wr(3'd0, 32'h1D0);
                wait_irq(n); chk("R9 wrap period", 32'(n), 32'(k));
            end
        end

        // R9 free-running up count on channel 1
        quiesce();
        wr(3'd4, 32'h90);
        for (int g = 0; g <= 3; g++) begin
            rd(3'd6, a); idle(g); rd(3'd6, b);
            chk("R9 free run step", b - a, 32'(g + 1));
        end

        // R10 one-shot stops at terminal
        quiesce();
        start(3'd0, 32'd3, 32'hC2);
        wait_irq(n); chk("R10 event", 32'(n), 32'd4);
        wr(3'd0, 32'h1C2);
        seen = 0;
        for (int k = 0; k < 10; k++) begin idle(1); if (irq) seen = 1; end
        chk("R10 no repeat", {31'b0, seen}, 32'h0);
        rd(3'd2, v); chk("R10 held at 0", v, 32'h0);
        rd(3'd0, v); chk("R10 flag clear", v, 32'hC2);

        // R11 disable freezes count
        quiesce();
        start(3'd0, 32'd1000, 32'h82);
        idle(5);
        wr(3'd0, 32'h02);
        rd(3'd2, a); chk("R11 frozen value", a, 32'd994);
        idle(3);
        rd(3'd2, b); chk("R11 still frozen", b, 32'd994);

        // R13 inert bits stored, timing unchanged
        quiesce();
        start(3'd0, 32'd5, 32'h2DF);
        wait_irq(n); chk("R13 timing", 32'(n), 32'd6);
        rd(3'd0, v); chk("R13 readback", v, 32'h3DF);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule